// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor request port and a block-wide memory port. Every line carries a valid flag, a dirty flag, a tag and one block of data words. The word address is split into tag (upper bits), line index (middle bits) and word offset (lowest bits). A lookup hits only when the indexed line is valid and its stored tag equals the request tag.

A misses runs a short sequence over the memory port. In write-back mode a dirty victim is first written to memory as a whole block, and then the requested block is fetched. A write miss allocates the line: the fetched block is merged with the store word. In write-through mode, chosen by a parameter, no line is ever marked dirty. Every store sends the updated block to memory, and the processor is released only after memory acknowledges it. The processor port holds `cpu_ready` low until the whole sequence is done, then raises it for exactly one cycle.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses and fetches its block. `cpu_ready` and `mem_valid` are low in the cycle after reset.
- R2: A hit needs the indexed line to be valid and its tag (address bits [11:6] by default, index bits [5:2], offset bits [1:0]) to match. A read hit returns data with `cpu_ready` seen two cycles after the request is raised, and it makes no memory request.
- R3: A read always returns the most recent value written to that word address, in both modes.
- R4: In write-back mode a write hit updates only the cache: no memory transfer takes place and the line becomes dirty.
- R5: In write-back mode a miss on a valid dirty line first writes the old block, with all of its latest words, to block address {old tag, index}. Only after that does it read the new block.
- R6: A miss on a clean or invalid line issues one block read and no memory write.
- R7: A line refilled by a read miss is clean, so evicting it later causes no write-back.
- R8: In write-through mode each write sends the whole updated block to its own block address before `cpu_ready` rises, and no miss ever writes a victim.
- R9: `cpu_ready` is a single-cycle pulse, one per request. While a memory request is waiting for `mem_ready`, the controller holds `mem_valid`, `mem_we` and `mem_addr` stable.
- R10: A write miss keeps the other words of the fetched block and replaces only the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | LINE_W | Block write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | LINE_W | Block read data, valid with `mem_ready` |

## Verification
The assertions assume that the processor keeps `cpu_valid`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable from raising the request until it sees `cpu_ready`. They also assume that memory raises `mem_ready` only while `mem_valid` is high and returns valid block data in that cycle. The bench meets both assumptions. It changes processor inputs only on falling edges, and only after the ready pulse. Its memory model answers each request after a fixed delay, with a one-cycle ready that is gated by `mem_valid`. Both policies are run side by side on the same request stream, so read data can be compared against one shared expected image of memory.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU,
    ST_DONE
  } cache_state_t;
endpackage

// File: rtl/dm_cache_data_ram.sv
module dm_cache_data_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/dm_cache_tag_store.sv
module dm_cache_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_dirty
);
  logic [LINES-1:0] valid_bits;
  logic [LINES-1:0] dirty_bits;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_bits <= '0;
      dirty_bits <= '0;
    end else if (upd_en) begin
      valid_bits[upd_idx] <= 1'b1;
      dirty_bits[upd_idx] <= upd_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) tags[upd_idx] <= upd_tag;
  end

  assign lk_valid = valid_bits[lk_idx];
  assign lk_dirty = dirty_bits[lk_idx];
  assign lk_tag   = tags[lk_idx];

  // R1: the cycle after reset leaves no line valid
  a_r1_cleared: assert property (@(posedge clk) rst |=> (valid_bits == '0));
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int LINE_WORDS    = 4,
  parameter int LINES         = 16,
  parameter bit WRITE_THROUGH = 1'b0,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = DATA_W * LINE_WORDS,
  localparam int BLK_AW = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [BLK_AW-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata
);
  cache_state_t      st;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [LINE_W-1:0] line_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic [BLK_AW-1:0] req_blk;
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_off = req_addr[OFF_W-1:0];
  assign req_blk = req_addr[ADDR_W-1:OFF_W];

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [DATA_W-1:0] word);
    logic [LINE_W-1:0] r;
    r = line;
    r[off*DATA_W +: DATA_W] = word;
    return r;
  endfunction

  logic              ram_rd_en;
  logic [LINE_W-1:0] ram_rdata;
  logic              ram_we;
  logic [LINE_W-1:0] ram_wdata;
  logic              ts_valid, ts_dirty, ts_upd, ts_upd_dirty;
  logic [TAG_W-1:0]  ts_tag;

  assign ram_rd_en = (st == ST_IDLE) && cpu_valid;

  dm_cache_data_ram #(.DEPTH(LINES), .WIDTH(LINE_W)) u_data (
    .clk     (clk),
    .rd_en   (ram_rd_en),
    .rd_addr (cpu_addr[OFF_W +: IDX_W]),
    .rd_data (ram_rdata),
    .wr_en   (ram_we),
    .wr_addr (req_idx),
    .wr_data (ram_wdata)
  );

  dm_cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (req_idx),
    .lk_valid  (ts_valid),
    .lk_dirty  (ts_dirty),
    .lk_tag    (ts_tag),
    .upd_en    (ts_upd),
    .upd_idx   (req_idx),
    .upd_tag   (req_tag),
    .upd_dirty (ts_upd_dirty)
  );

  logic              hit;
  logic [LINE_W-1:0] hit_line, fill_line;
  assign hit       = ts_valid && (ts_tag == req_tag);
  assign hit_line  = put_word(ram_rdata, req_off, req_wdata);
  assign fill_line = req_we ? put_word(mem_rdata, req_off, req_wdata) : mem_rdata;

  always_comb begin
    ram_we       = 1'b0;
    ram_wdata    = fill_line;
    ts_upd       = 1'b0;
    ts_upd_dirty = 1'b0;
    if (st == ST_LOOKUP && hit && req_we) begin
      ram_we       = 1'b1;
      ram_wdata    = hit_line;
      ts_upd       = 1'b1;
      ts_upd_dirty = !WRITE_THROUGH;
    end else if (st == ST_FILL && mem_ready) begin
      ram_we       = 1'b1;
      ts_upd       = 1'b1;
      ts_upd_dirty = !WRITE_THROUGH && req_we;
    end
  end

  assign mem_valid = (st == ST_EVICT) || (st == ST_FILL) || (st == ST_WTHRU);
  assign mem_we    = (st == ST_EVICT) || (st == ST_WTHRU);
  assign mem_addr  = (st == ST_EVICT) ? {ts_tag, req_idx} : req_blk;
  assign mem_wdata = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      line_q    <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (st)
        ST_IDLE: if (cpu_valid) begin
          req_we    <= cpu_we;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          st        <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            line_q    <= req_we ? hit_line : ram_rdata;
            cpu_rdata <= ram_rdata[req_off*DATA_W +: DATA_W];
            if (req_we && WRITE_THROUGH) st <= ST_WTHRU;
            else begin
              st        <= ST_DONE;
              cpu_ready <= 1'b1;
            end
          end else begin
            line_q <= ram_rdata;
            st     <= (!WRITE_THROUGH && ts_valid && ts_dirty) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ready) st <= ST_FILL;
        ST_FILL: if (mem_ready) begin
          line_q    <= fill_line;
          cpu_rdata <= mem_rdata[req_off*DATA_W +: DATA_W];
          if (req_we && WRITE_THROUGH) st <= ST_WTHRU;
          else begin
            st        <= ST_DONE;
            cpu_ready <= 1'b1;
          end
        end
        ST_WTHRU: if (mem_ready) begin
          st        <= ST_DONE;
          cpu_ready <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: quiet ports right after reset
  a_r1_quiet: assert property (@(posedge clk) rst |=> (!cpu_ready && !mem_valid));
  // R9: completion is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst) cpu_ready |=> !cpu_ready);
  // R9: a pending memory request does not change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));
  // R2: a read hit completes next cycle with no memory request
  a_r2_hit_fast: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOKUP && hit && !req_we) |=> (cpu_ready && !mem_valid));
  // R5: a victim write is followed at once by the read of the requested block
  a_r5_order: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we && mem_ready && mem_addr != req_blk)
      |=> (mem_valid && !mem_we && mem_addr == req_blk));

  generate
    if (WRITE_THROUGH) begin : g_wt_chk
      // R8: memory writes only ever target the requested block
      a_r8_no_victim: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> (mem_addr == req_blk));
    end else begin : g_wb_chk
      // R4: a write-back store hit never touches memory on the next cycle
      a_r4_hit_local: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOOKUP && hit && req_we) |=> !mem_valid);
    end
  endgenerate
endmodule

// File: tb/dm_cache_tb.sv
`timescale 1ns/1ps
module dm_cache_mem_model #(
  parameter int BAW = 10,
  parameter int LW  = 128,
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic           we,
  input  logic [BAW-1:0] addr,
  input  logic [LW-1:0]  wdata,
  output logic           ready,
  output logic [LW-1:0]  rdata,
  output int             wr_cnt,
  output int             rd_cnt,
  output logic [BAW-1:0] last_waddr,
  output logic [LW-1:0]  last_wdata
);
  logic [LW-1:0] mem [1<<BAW];
  int cnt;
  initial begin
    for (int a = 0; a < (1<<BAW); a++)
      for (int w = 0; w < LW/32; w++) mem[a][w*32 +: 32] = {20'hC0DE0, a[9:0], w[1:0]};
  end
  always @(posedge clk) begin
    if (rst) begin
      ready <= 0; cnt <= 0; wr_cnt <= 0; rd_cnt <= 0; rdata <= '0;
      last_waddr <= '0; last_wdata <= '0;
    end else if (ready) begin
      ready <= 0; cnt <= 0;
      if (valid && we) begin
        mem[addr] <= wdata; wr_cnt <= wr_cnt + 1;
        last_waddr <= addr; last_wdata <= wdata;
      end else if (valid) rd_cnt <= rd_cnt + 1;
    end else if (valid) begin
      if (cnt == LAT) begin ready <= 1; rdata <= mem[addr]; end
      else cnt <= cnt + 1;
    end else cnt <= 0;
  end
endmodule

module dm_cache_tb;
  localparam int AW = 12, DW = 32, LWD = 4, NL = 16, LW = 128, BAW = 10;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic c_valid[2], c_we[2], c_ready[2];
  logic [AW-1:0] c_addr[2];
  logic [DW-1:0] c_wdata[2], c_rdata[2];
  logic m_valid[2], m_we[2], m_ready[2];
  logic [BAW-1:0] m_addr[2], m_lwa[2];
  logic [LW-1:0] m_wdata[2], m_rdata[2], m_lwd[2];
  int m_wr[2], m_rd[2];

  dm_cache #(.WRITE_THROUGH(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cpu_valid(c_valid[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
    .cpu_wdata(c_wdata[0]), .cpu_ready(c_ready[0]), .cpu_rdata(c_rdata[0]),
    .mem_valid(m_valid[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wdata(m_wdata[0]),
    .mem_ready(m_ready[0]), .mem_rdata(m_rdata[0]));
  dm_cache #(.WRITE_THROUGH(1'b1)) u_dut_wt (
    .clk(clk), .rst(rst), .cpu_valid(c_valid[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
    .cpu_wdata(c_wdata[1]), .cpu_ready(c_ready[1]), .cpu_rdata(c_rdata[1]),
    .mem_valid(m_valid[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wdata(m_wdata[1]),
    .mem_ready(m_ready[1]), .mem_rdata(m_rdata[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mem
    dm_cache_mem_model #(.BAW(BAW), .LW(LW), .LAT(2 + g)) u_mem (
      .clk(clk), .rst(rst), .valid(m_valid[g]), .we(m_we[g]), .addr(m_addr[g]),
      .wdata(m_wdata[g]), .ready(m_ready[g]), .rdata(m_rdata[g]), .wr_cnt(m_wr[g]),
      .rd_cnt(m_rd[g]), .last_waddr(m_lwa[g]), .last_wdata(m_lwd[g]));
  end

  int errors = 0, checks = 0;
  logic [DW-1:0] cv [1<<AW];
  bit rv[2][NL], rdty[2][NL];
  int rt[2][NL];
  int exp_wr[2], exp_rd[2];
  bit ev[2], hitr[2];
  int ev_tag[2];
  logic [DW-1:0] got[2];
  int lat[2];

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic issue(int m, bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    int n = 0;
    @(negedge clk);
    c_valid[m] = 1; c_we[m] = we; c_addr[m] = a; c_wdata[m] = d;
    do begin @(negedge clk); n++; end while (!c_ready[m] && n < 5000);
    got[m] = c_rdata[m]; lat[m] = n; c_valid[m] = 0;
  endtask

  task automatic predict(int m, bit we, logic [AW-1:0] a);
    int tg = int'(a[11:6]); int ix = int'(a[5:2]);
    bit h = rv[m][ix] && rt[m][ix] == tg;
    ev[m] = 0; hitr[m] = h && !we;
    if (!h) begin
      if (m == 0 && rv[m][ix] && rdty[m][ix]) begin ev[m] = 1; ev_tag[m] = rt[m][ix]; exp_wr[m]++; end
      exp_rd[m]++;
    end
    if (m == 1 && we) exp_wr[m]++;
    if (m == 0) rdty[m][ix] = we ? 1'b1 : (h ? rdty[m][ix] : 1'b0);
    rv[m][ix] = 1; rt[m][ix] = tg;
  endtask

  task automatic op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    for (int m = 0; m < 2; m++) predict(m, we, a);
    fork
      issue(0, we, a, d);
      issue(1, we, a, d);
    join
    for (int m = 0; m < 2; m++) begin
      string tagm = {req, (m == 0) ? "/wb" : "/wt"};
      if (!we) check(got[m] == cv[a], {"R3 ", tagm}, got[m], cv[a]);
      if (hitr[m]) check(lat[m] == 2, {"R2 ", tagm}, lat[m], 2);
      check(m_rd[m] == exp_rd[m], {"R6 reads ", tagm}, m_rd[m], exp_rd[m]);
      check(m_wr[m] == exp_wr[m], {(m == 0) ? "R4 writes " : "R8 writes ", tagm}, m_wr[m], exp_wr[m]);
      if (ev[m]) begin
        logic [BAW-1:0] vb = {ev_tag[m][5:0], a[5:2]};
        check(m_lwa[m] == vb, {"R5 victim addr ", tagm}, m_lwa[m], vb);
        for (int w = 0; w < LWD; w++)
          check(m_lwd[m][w*32 +: 32] == cv[{vb, w[1:0]}], {"R5 victim data ", tagm},
                m_lwd[m][w*32 +: 32], cv[{vb, w[1:0]}]);
      end
      if (m == 1 && we) begin
        check(m_lwa[1] == a[11:2], "R8 block addr", m_lwa[1], a[11:2]);
        check(m_lwd[1][a[1:0]*32 +: 32] == d, "R8 block data", m_lwd[1][a[1:0]*32 +: 32], d);
      end
    end
    if (we) cv[a] = d;
  endtask

  function automatic logic [AW-1:0] mk(int t, int i, int o);
    return {t[5:0], i[3:0], o[1:0]};
  endfunction

  initial begin
    int seed = 7;
    for (int i = 0; i < (1<<AW); i++) cv[i] = {20'hC0DE0, i[11:0]};
    for (int m = 0; m < 2; m++) begin
      c_valid[m] = 0; c_we[m] = 0; c_addr[m] = 0; c_wdata[m] = 0;
      exp_wr[m] = 0; exp_rd[m] = 0;
      for (int i = 0; i < NL; i++) begin rv[m][i] = 0; rdty[m][i] = 0; rt[m][i] = 0; end
    end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(!c_ready[m], "R1 ready low", c_ready[m], 0);
      check(!m_valid[m], "R1 mem idle", m_valid[m], 0);
    end
    op(0, mk(1, 3, 0), 0, "R1 cold miss");
    op(0, mk(1, 3, 2), 0, "R2 hit");
    op(1, mk(1, 3, 1), 32'hAAAA_0001, "R4 write hit");
    op(0, mk(1, 3, 1), 0, "R3 read back");
    op(0, mk(1, 4, 0), 0, "R2 other index");
    op(0, mk(2, 3, 0), 0, "R5 dirty evict");
    op(0, mk(1, 3, 1), 0, "R7 clean refill");
    op(1, mk(5, 7, 2), 32'hBBBB_0002, "R10 write miss");
    op(0, mk(5, 7, 3), 0, "R10 neighbour");
    op(0, mk(5, 7, 2), 0, "R10 stored word");
    op(0, mk(9, 7, 0), 0, "R5 evict merged");
    op(0, mk(5, 7, 0), 0, "R6 clean victim");
    for (int k = 0; k < 80; k++) begin
      seed = seed * 1103515245 + 12345;
      op(seed[20], mk(seed[17:16], seed[13:12], seed[9:8]), seed, "R9 mixed");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule